// File: doc/BRIEF.md
# Edge-Triggered Up/Down Counter with Wrap Flags

This block is a signed counter with two rung inputs, one for counting up and one for counting down, that share a single accumulator. A counting step happens only when a rung goes from low to high. A rung that stays high adds nothing more. The accumulator is compared against a signed preset to produce a done flag. When the count runs past the most positive or most negative value, it wraps around, and a sticky overflow or underflow flag records the event.

A synchronous clear command returns the accumulator and all flags to zero. The hardware reset arms both edge detectors as though each rung had already been high. Because of this, a rung that is asserted while the block comes out of reset is not taken as a first count. All state is presented on one 16-bit status word beside the accumulator value.

Top module: `updn_edge_counter`

## Requirements
- R1: Status word layout: bit 15 is the up-rung enable, bit 14 the down-rung enable, bit 13 done, bit 12 overflow, bit 11 underflow, and bits 10..0 are zero. Each enable bit shows the level its rung had at the previous clock edge.
- R2: A low-to-high transition of the up rung raises the accumulator by one on the next clock edge. Holding the rung high produces no further counts.
- R3: A low-to-high transition of the down rung lowers the accumulator by one on the next clock edge.
- R4: If up and down transitions land on the same clock edge, they cancel and the accumulator keeps its value.
- R5: Done (bit 13) is high exactly when the accumulator, read as two's complement, is greater than or equal to the preset, also read as two's complement. It follows the current accumulator and preset with no extra delay.
- R6: An up step from the most positive value wraps the accumulator to the most negative value and sets overflow. Overflow stays set through further counting.
- R7: A down step from the most negative value wraps the accumulator to the most positive value and sets underflow. Underflow stays set through further counting.
- R8: A wrap in the opposite direction of a set flag clears that flag and does not set its own. A down wrap clears overflow, and an up wrap clears underflow.
- R9: While the hardware reset is asserted, both enable bits read 1 and the accumulator reads 0. A rung already high at release produces no count.
- R10: The clear command zeroes the accumulator, both enables, overflow and underflow on the next edge, and it overrides any count in that cycle. A rung still high after the clear ends counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| up_rung | input | 1 | Count-up rung level |
| dn_rung | input | 1 | Count-down rung level |
| clr_cmd | input | 1 | Synchronous clear command |
| preset | input | W | Signed preset compared against the accumulator |
| acc | output | W | Signed accumulator |
| status | output | 16 | Enable, done, overflow and underflow flags |

## Verification
The bench holds a rung high through reset release and after a clear. A design without the armed edge detectors would count one step at reset release. A design that fails to re-arm after a clear would skip a count. It applies simultaneous up and down edges, which an adder handling only one of them would turn into a net step. It gives a negative preset, which an unsigned comparator would read as a large number and report done wrongly. It drives the count across both limits and back again, so a design that forgets a sticky flag, sets a flag on the return crossing, or leaves the opposite flag set would show the wrong status bits.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int STAT_W    = 16;
  localparam int BIT_UPEN  = 15;
  localparam int BIT_DNEN  = 14;
  localparam int BIT_DONE  = 13;
  localparam int BIT_OVF   = 12;
  localparam int BIT_UNF   = 11;
  localparam int N_RUNGS   = 2;
  localparam int RUNG_UP   = 0;
  localparam int RUNG_DN   = 1;
endpackage

// File: rtl/updn_rung_edge.sv
module updn_rung_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rung,
  output logic en_flag,
  output logic pulse
);
  logic prev_q;

  // Reset arms the detector as if the rung was already high (prescan).
  always_ff @(posedge clk) begin
    if (!rst_n)   prev_q <= 1'b1;
    else if (clr) prev_q <= 1'b0;
    else          prev_q <= rung;
  end

  assign en_flag = prev_q;
  assign pulse   = rung & ~prev_q;

  // R2
  edge_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !clr) |=> en_flag);
  // R10
  clear_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !en_flag);
endmodule

// File: rtl/updn_acc.sv
module updn_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc_p,
  input  logic         dec_p,
  output logic [W-1:0] acc,
  output logic         ovf,
  output logic         unf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] next_value(input logic [W-1:0] cur,
                                              input logic up, input logic dn);
    if (up && !dn)      return cur + ONE;
    else if (dn && !up) return cur - ONE;
    else                return cur;
  endfunction

  logic [W-1:0] acc_q;
  logic         ovf_q, unf_q;
  logic         up_only, dn_only, wrap_hi, wrap_lo;

  assign up_only = inc_p & ~dec_p;
  assign dn_only = dec_p & ~inc_p;
  assign wrap_hi = up_only & (acc_q == MAXV);
  assign wrap_lo = dn_only & (acc_q == MINV);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      acc_q <= next_value(acc_q, inc_p, dec_p);
      if (wrap_hi) begin
        if (unf_q) unf_q <= 1'b0;
        else       ovf_q <= 1'b1;
      end
      if (wrap_lo) begin
        if (ovf_q) ovf_q <= 1'b0;
        else       unf_q <= 1'b1;
      end
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;
  assign unf = unf_q;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_only && !clr) |=> (acc == $past(acc) + ONE));
  // R4
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_p && dec_p && !clr) |=> $stable(acc));
  // R6
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hi && !unf_q && !clr) |=> (ovf && acc == MINV));
  // R7
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_lo && !ovf_q && !clr) |=> (unf && acc == MAXV));
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  // R10
  clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !ovf && !unf));
endmodule

// File: rtl/updn_status.sv
module updn_status
  import updn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      acc,
  input  logic [W-1:0]      preset,
  input  logic              en_up,
  input  logic              en_dn,
  input  logic              ovf,
  input  logic              unf,
  output logic [STAT_W-1:0] status
);
  function automatic logic reached(input logic [W-1:0] a, input logic [W-1:0] p);
    return $signed(a) >= $signed(p);
  endfunction

  always_comb begin
    status           = '0;
    status[BIT_UPEN] = en_up;
    status[BIT_DNEN] = en_dn;
    status[BIT_DONE] = reached(acc, preset);
    status[BIT_OVF]  = ovf;
    status[BIT_UNF]  = unf;
  end
endmodule

// File: rtl/updn_edge_counter.sv
module updn_edge_counter
  import updn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_rung,
  input  logic              dn_rung,
  input  logic              clr_cmd,
  input  logic [W-1:0]      preset,
  output logic [W-1:0]      acc,
  output logic [STAT_W-1:0] status
);
  logic [N_RUNGS-1:0] rung_vec, en_vec, pulse_vec;
  logic               ovf_w, unf_w;

  assign rung_vec[RUNG_UP] = up_rung;
  assign rung_vec[RUNG_DN] = dn_rung;

  for (genvar g = 0; g < N_RUNGS; g++) begin : g_rung
    updn_rung_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_cmd),
      .rung    (rung_vec[g]),
      .en_flag (en_vec[g]),
      .pulse   (pulse_vec[g])
    );
  end

  updn_acc #(.W(W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_cmd),
    .inc_p (pulse_vec[RUNG_UP]),
    .dec_p (pulse_vec[RUNG_DN]),
    .acc   (acc),
    .ovf   (ovf_w),
    .unf   (unf_w)
  );

  updn_status #(.W(W)) u_status (
    .acc    (acc),
    .preset (preset),
    .en_up  (en_vec[RUNG_UP]),
    .en_dn  (en_vec[RUNG_DN]),
    .ovf    (ovf_w),
    .unf    (unf_w),
    .status (status)
  );

  // R1
  status_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_UNF-1:0] == '0);
endmodule

// File: tb/updn_edge_counter_bench.sv
module updn_edge_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n, up_rung, dn_rung, clr_cmd;
  logic [15:0] preset, acc, status;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  updn_edge_counter u_updn_edge_counter (
    .clk(clk), .rst_n(rst_n), .up_rung(up_rung), .dn_rung(dn_rung),
    .clr_cmd(clr_cmd), .preset(preset), .acc(acc), .status(status)
  );

  // {clr, up, dn, preset, expected acc, expected status}
  localparam int NV = 21;
  localparam logic [50:0] VEC [NV] = '{
    {3'b000, 16'h0004, 16'h0000, 16'h0000}, // R2 idle
    {3'b010, 16'h0004, 16'h0001, 16'h8000}, // R2 R1
    {3'b000, 16'h0004, 16'h0001, 16'h0000},
    {3'b010, 16'h0004, 16'h0002, 16'h8000},
    {3'b000, 16'h0004, 16'h0002, 16'h0000},
    {3'b010, 16'h0004, 16'h0003, 16'h8000},
    {3'b000, 16'h0004, 16'h0003, 16'h0000},
    {3'b010, 16'h0004, 16'h0004, 16'hA000}, // R5 done at preset
    {3'b001, 16'h0004, 16'h0003, 16'h4000}, // R3 R5
    {3'b010, 16'h0004, 16'h0004, 16'hA000},
    {3'b011, 16'h0004, 16'h0003, 16'hC000}, // R3 only down edge
    {3'b000, 16'h0004, 16'h0003, 16'h0000},
    {3'b011, 16'h0004, 16'h0003, 16'hC000}, // R4 cancel
    {3'b000, 16'h0004, 16'h0003, 16'h0000},
    {3'b110, 16'h0004, 16'h0000, 16'h0000}, // R10 clear
    {3'b010, 16'h0004, 16'h0001, 16'h8000}, // R10 held rung counts
    {3'b000, 16'hFFFE, 16'h0001, 16'h2000}, // R5 negative preset
    {3'b001, 16'h0005, 16'h0000, 16'h4000},
    {3'b000, 16'h0005, 16'h0000, 16'h0000},
    {3'b001, 16'h0005, 16'hFFFF, 16'h4000}, // R3 below zero
    {3'b000, 16'hFFFF, 16'hFFFF, 16'h2000}  // R5 equal negative
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_up();
    up_rung = 1'b1; step(); up_rung = 1'b0; step();
  endtask

  task automatic pulse_dn();
    dn_rung = 1'b1; step(); dn_rung = 1'b0; step();
  endtask

  initial begin
    for (int c = 0; c < 195000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_rung = 1'b1; dn_rung = 1'b0; clr_cmd = 1'b0; preset = 16'd4;
    step(); step(); step();
    chk("R9 reset status", status, 16'hC000);
    chk("R9 reset acc", acc, 16'h0000);
    rst_n = 1'b1;
    step();
    chk("R9 held rung no count", acc, 16'h0000);
    chk("R1 enables follow rungs", status, 16'h8000);

    for (int i = 0; i < NV; i++) begin
      clr_cmd = VEC[i][50]; up_rung = VEC[i][49]; dn_rung = VEC[i][48];
      preset  = VEC[i][47:32];
      step();
      chk($sformatf("R1/R2/R3/R4/R5/R10 vector %0d acc", i), acc, VEC[i][31:16]);
      chk($sformatf("R1/R2/R3/R4/R5/R10 vector %0d status", i), status, VEC[i][15:0]);
    end

    up_rung = 1'b0; dn_rung = 1'b0; preset = 16'd4;
    clr_cmd = 1'b1; step(); clr_cmd = 1'b0;
    for (int k = 0; k < 32767; k++) pulse_up();
    chk("R2 reach max", acc, 16'h7FFF);
    pulse_up();
    chk("R6 wrap acc", acc, 16'h8000);
    chk("R6 ovf set", status & 16'h1800, 16'h1000);
    pulse_up();
    chk("R6 ovf sticky", status & 16'h1800, 16'h1000);
    pulse_dn();
    pulse_dn();
    chk("R8 back across acc", acc, 16'h7FFF);
    chk("R8 ovf cleared no unf", status & 16'h1800, 16'h0000);
    pulse_up();
    chk("R6 ovf again", status & 16'h1800, 16'h1000);
    clr_cmd = 1'b1; up_rung = 1'b1; step();
    chk("R10 clear beats edge acc", acc, 16'h0000);
    chk("R10 clear flags", status, 16'h0000);
    clr_cmd = 1'b0; up_rung = 1'b0; step();
    chk("R10 no count after", acc, 16'h0000);

    for (int k = 0; k < 32768; k++) pulse_dn();
    chk("R3 reach min", acc, 16'h8000);
    chk("R7 no flag at min", status & 16'h1800, 16'h0000);
    pulse_dn();
    chk("R7 wrap acc", acc, 16'h7FFF);
    chk("R7 unf set", status & 16'h1800, 16'h0800);
    pulse_dn();
    chk("R7 unf sticky", status & 16'h1800, 16'h0800);
    pulse_up();
    pulse_up();
    chk("R8 up across acc", acc, 16'h8000);
    chk("R8 unf cleared no ovf", status & 16'h1800, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule